// File: doc/BRIEF.md
# Iterative Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and delivers the full signed product of `2*WIDTH` bits. It works one multiplier bit per clock. In each step it looks at the lowest bit of the partial register and at a guard bit sitting just right of it. From that pair it subtracts the multiplicand from the upper half, adds it, or leaves the upper half alone. It then shifts the whole register right by one place, filling from the sign. A run of ones in the multiplier therefore costs one subtraction where the run begins and one addition just past its end.

Operands enter on a valid/ready stream and the product leaves on another. A transfer happens on a rising clock edge where both valid and ready are high. The input side is ready only while the unit is idle, so a new pair is taken only after the previous product has been handed off. The output side keeps its valid and its data steady for as long as the consumer holds ready low. That back-pressure also stalls the input side.

Top module: `booth_mul`

## Requirements
- R1: `out_product` equals the signed product `in_mcand * in_mplier`, written as a `2*WIDTH`-bit two's-complement value, for every pair of operands.
- R2: Operands at the most negative value are handled without losing the sign. When `in_mcand` is -2^(WIDTH-1) (also when it is squared), the product is still exact.
- R3: After reset `in_ready` is 1 and `out_valid` is 0. `in_ready` is 1 only while no operation is in flight and no product waits to be taken, and it returns to 1 on the edge where the product is taken.
- R4: A pair is accepted on an edge with `in_valid` and `in_ready` both 1. `out_valid` rises on the `WIDTH`-th rising edge after that accepting edge, and never earlier.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_product` keeps its value. The product is consumed on the edge where both are 1, and `out_valid` is 0 after that edge.
- R6: Values on `in_valid`, `in_mcand` and `in_mplier` while `in_ready` is 0 have no effect on the product being computed.
- R7: Each step recodes the pair (current bit, right bit) as follows: (1,0) subtracts the multiplicand from the upper half; (0,1) adds it; (0,0) and (1,1) leave the upper half unchanged. The right bit is 0 for the first step. Examples: 2×7 gives 14, 2×(−3) gives −6, and 3×(−1) gives −3.
- R8: Each step ends with an arithmetic right shift of the combined register. The bit shifted out becomes the right bit for the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Unit idle and able to take a pair |
| in_mcand | input | WIDTH | Signed multiplicand |
| in_mplier | input | WIDTH | Signed multiplier |
| out_valid | output | 1 | Product present |
| out_ready | input | 1 | Consumer takes the product |
| out_product | output | 2*WIDTH | Signed product |

## Verification
The stability assertions assume the consumer's ready is the only thing that releases a waiting product. They also assume that operand pins matter only on an accepting edge. The stimulus changes the operands to unrelated values and keeps `in_valid` high for the whole busy period, which puts that assumption under test rather than relying on it quietly. The bench uses a 6-bit configuration and sweeps every operand pair. On a share of the pairs it holds `out_ready` low for a few cycles, so that stalled and unstalled hand-offs both follow each latency measurement.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mul_state_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      cur_bit,
  input  logic      right_bit,
  output booth_op_e op
);

  // R7: start of a run subtracts, end of a run adds, otherwise nothing
  always_comb begin
    unique case ({cur_bit, right_bit})
      2'b10:   op = OP_SUB;
      2'b01:   op = OP_ADD;
      default: op = OP_NONE;
    endcase
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int XW = WIDTH + 1
) (
  input  logic [WIDTH-1:0] upper,
  input  logic [WIDTH-1:0] mcand,
  input  booth_op_e        op,
  output logic [XW-1:0]    result
);

  logic [XW-1:0] upper_x;
  logic [XW-1:0] mcand_x;

  // one guard bit so that subtracting the most negative value keeps its sign (R2)
  assign upper_x = {upper[WIDTH-1], upper};
  assign mcand_x = {mcand[WIDTH-1], mcand};

  always_comb begin
    unique case (op)
      OP_ADD:  result = upper_x + mcand_x;
      OP_SUB:  result = upper_x - mcand_x;
      default: result = upper_x;
    endcase
  end

endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl
  import booth_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic load,
  output logic step,
  output logic out_valid
);

  mul_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          last_step;

  assign last_step = (cnt_q == CW'(WIDTH - 1));
  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_DONE);
  assign load      = in_ready && in_valid;
  assign step      = (state_q == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (in_valid) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          if (last_step) state_q <= ST_DONE;
          else           cnt_q   <= cnt_q + 1'b1;
        end
        ST_DONE: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt_q <= CW'(WIDTH - 1)));

  a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(step && last_step));

  a_r5_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  a_r3_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && (out_valid || step)));

endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int PW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_mcand,
  input  logic [WIDTH-1:0] in_mplier,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PW-1:0]    out_product
);

  logic             load;
  logic             step;
  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH-1:0] upper_q;
  logic [WIDTH-1:0] lower_q;
  logic             guard_q;
  booth_op_e        op;
  logic [WIDTH:0]   sum;

  booth_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .load      (load),
    .step      (step),
    .out_valid (out_valid)
  );

  booth_recode u_recode (
    .cur_bit   (lower_q[0]),
    .right_bit (guard_q),
    .op        (op)
  );

  booth_addsub #(.WIDTH(WIDTH)) u_addsub (
    .upper  (upper_q),
    .mcand  (mcand_q),
    .op     (op),
    .result (sum)
  );

  // R8: arithmetic right shift of {sum, lower}; shifted-out bit becomes guard
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      upper_q <= '0;
      lower_q <= '0;
      guard_q <= 1'b0;
    end else if (load) begin
      mcand_q <= in_mcand;
      upper_q <= '0;
      lower_q <= in_mplier;
      guard_q <= 1'b0;
    end else if (step) begin
      upper_q <= sum[WIDTH:1];
      lower_q <= {sum[0], lower_q[WIDTH-1:1]};
      guard_q <= lower_q[0];
    end
  end

  assign out_product = {upper_q, lower_q};

  a_r5_product_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_product));

  a_r6_mcand_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (step || out_valid) |=> $stable(mcand_q));

  a_r7_guard_clear_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (guard_q == 1'b0 && upper_q == '0));

  a_r8_guard_tracks_shift: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (guard_q == $past(lower_q[0])));

endmodule

// File: tb/booth_mul_test.sv
module booth_mul_test;
  localparam int W  = 6;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_mcand = '0;
  logic [W-1:0]  in_mplier = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic signed [PW-1:0] out_product;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  booth_mul #(.WIDTH(W)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_mcand    (in_mcand),
    .in_mplier   (in_mplier),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_product (out_product)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic mul_once(input int av, input int bv, input int hold, input string req);
    longint exp;
    int     lat;
    exp = longint'(av) * longint'(bv);
    @(negedge clk);
    in_mcand  = W'(av);
    in_mplier = W'(bv);
    in_valid  = 1'b1;
    @(negedge clk);
    // R6: keep offering different operands while busy
    in_mcand  = W'(av + 5);
    in_mplier = W'(~bv);
    lat = 1;
    while (!out_valid && lat < 4 * W) begin
      if (in_ready) check(1'b0, "R3 busy ready", 1, 0);
      @(negedge clk);
      lat++;
    end
    in_valid = 1'b0;
    check(lat == W + 1, "R4 latency", lat, W + 1);
    check(longint'(out_product) == exp, req, longint'(out_product), exp);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(out_valid && longint'(out_product) == exp, "R5 stall hold",
            longint'(out_product), exp);
      check(!in_ready, "R3 ready during stall", in_ready, 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R5 consume", {out_valid, in_ready}, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R3 reset ready", in_ready, 1);
    check(out_valid == 1'b0, "R3 reset valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !out_valid, "R3 after reset", {in_ready, out_valid}, 2);

    // R7 recoding examples
    mul_once(2, 7, 0, "R7 2x7");
    mul_once(2, -3, 1, "R7 2x-3");
    mul_once(3, -1, 0, "R7 3x-1 single subtract");
    mul_once(-21, 21, 0, "R8 alternating bits");
    // R2 most negative corners
    mul_once(-32, -32, 2, "R2 min squared");
    mul_once(-32, 31, 0, "R2 min times max");
    mul_once(31, -32, 0, "R2 max times min");
    mul_once(-32, 1, 0, "R2 min times one");

    // R1 exhaustive sweep
    for (int ai = -32; ai < 32; ai++) begin
      for (int bi = -32; bi < 32; bi++) begin
        mul_once(ai, bi, (((ai ^ bi) & 7) == 0) ? 2 : 0, "R1 sweep");
      end
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule